// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

This block is a synchronous binary counter of parameterised width (four bits by default). It steps up or down on each rising clock edge while its active-low count enable is low, and a single direction input picks the sense. An active-low preset input forces the output to follow a parallel data word at once, whatever the clock is doing. The stored value is captured on the first rising edge after the preset is released, and no count happens on that edge.

Two outputs let several stages be chained into a wider counter. The terminal flag is high for a whole clock cycle whenever the count sits at its last value in the current direction: all ones when counting up, all zeros when counting down. The active-low ripple output carries the same condition, but it drops only while the clock is low and only while the stage is enabled. A following stage that shares the clock can be enabled from either output.

Control runs through a two-state phase machine. PRESET is entered asynchronously whenever the preset input is low. The transition PRESET to RUN happens on the first rising edge with the preset input high; on that edge the data word is captured and no count occurs. RUN to RUN continues on every later edge. In RUN, a step decoder picks HOLD (enable high), UP (enable low, direction low) or DOWN (enable low, direction high).

Top module: `updn_counter`

## Requirements
- R1: In RUN, with cnt_en_n low and down low, each rising edge adds one to count.
- R2: In RUN, with cnt_en_n low and down high, each rising edge subtracts one from count.
- R3: With cnt_en_n high, count keeps its value across rising edges.
- R4: While load_n is low, count equals pdata immediately and follows changes on pdata, whether clk is high or low, including across rising edges.
- R5: Counting wraps: up from all ones gives zero, and down from zero gives all ones.
- R6: term is 1 when count is all ones with down low, or when count is all zeros with down high; otherwise term is 0. term does not depend on cnt_en_n.
- R7: ripple_n is 0 only when term is 1, cnt_en_n is 0 and clk is low. It is 1 in every other case, and always 1 while clk is high.
- R8: On the first rising edge after load_n goes high, count takes the value of pdata and does not step. Counting resumes on the next edge.
- R9: Two stages sharing one clock, with the upper stage enabled only when the lower stage is enabled and its term is 1, form a counter of twice the width that carries when counting up and borrows when counting down.
- R10: Changes on cnt_en_n and down between rising edges do not change count; only their levels at the edge matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count updates on its rising edge |
| load_n | input | 1 | Active-low asynchronous preset |
| cnt_en_n | input | 1 | Active-low count enable |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| pdata | input | W | Parallel preset data |
| count | output | W | Current count |
| term | output | 1 | Terminal-count flag for the current direction |
| ripple_n | output | 1 | Active-low terminal pulse, present only during the low half of clk |

## Verification
The bench builds two instances with the default width of four bits and chains them through the lower stage's terminal flag into an eight-bit counter. The small width puts both terminal values and the wrap within a few edges. The chaining makes the carry from 0x0F to 0x10 and the borrow from 0x10 to 0x0F visible across the stage boundary. Presets to 0xFE and 0x1F bring the full eight-bit wrap, and the terminal flag under both directions and under inhibit, within a short run.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic {
        ST_PRESET = 1'b0,
        ST_RUN    = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/updn_phase_ctrl.sv
module updn_phase_ctrl
    import updn_pkg::*;
(
    input  logic   clk,
    input  logic   load_n,
    input  logic   cnt_en_n,
    input  logic   down,
    output phase_e phase,
    output step_e  step
);

    phase_e state_q;
    phase_e state_d;

    // State register: preset forces PRESET asynchronously.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            state_q <= ST_PRESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRESET: state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
            default:   state_d = ST_PRESET;
        endcase
    end

    // Output decode: the step applied at the coming edge.
    always_comb begin
        step = STEP_HOLD;
        unique case (state_q)
            ST_PRESET: step = STEP_HOLD;
            ST_RUN: begin
                if (!cnt_en_n) begin
                    step = down ? STEP_DOWN : STEP_UP;
                end
            end
            default: step = STEP_HOLD;
        endcase
    end

    assign phase = state_q;

endmodule

// File: rtl/updn_toggle_chain.sv
module updn_toggle_chain
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  step_e        step,
    output logic [W-1:0] nxt
);

    logic [W-1:0] tog;
    logic         go;
    logic         up;

    assign go     = (step != STEP_HOLD);
    assign up     = (step == STEP_UP);
    assign tog[0] = go;

    // Bit i flips when every lower bit sits at its terminal level.
    generate
        for (genvar i = 1; i < W; i++) begin : g_tog
            assign tog[i] = tog[i-1] & (up ? cur[i-1] : ~cur[i-1]);
        end
    endgenerate

    assign nxt = cur ^ tog;

endmodule

// File: rtl/updn_cascade_out.sv
module updn_cascade_out #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         cnt_en_n,
    input  logic         down,
    input  logic [W-1:0] cur,
    output logic         term,
    output logic         ripple_n
);

    logic at_top;
    logic at_bottom;

    assign at_top    = &cur;
    assign at_bottom = ~|cur;
    assign term      = down ? at_bottom : at_top;
    assign ripple_n  = ~(term & ~cnt_en_n & ~clk);

endmodule

// File: rtl/updn_counter.sv
module updn_counter
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         load_n,
    input  logic         cnt_en_n,
    input  logic         down,
    input  logic [W-1:0] pdata,
    output logic [W-1:0] count,
    output logic         term,
    output logic         ripple_n
);

    phase_e       phase;
    step_e        step;
    logic         running;
    logic         preset_path;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;

    updn_phase_ctrl u_ctrl (
        .clk      (clk),
        .load_n   (load_n),
        .cnt_en_n (cnt_en_n),
        .down     (down),
        .phase    (phase),
        .step     (step)
    );

    updn_toggle_chain #(.W(W)) u_chain (
        .cur  (cnt_q),
        .step (step),
        .nxt  (cnt_nxt)
    );

    assign running     = (phase == ST_RUN);
    assign preset_path = !load_n || !running;

    // Preset data captured while in the preset path; otherwise step.
    always_ff @(posedge clk) begin
        if (preset_path) begin
            cnt_q <= pdata;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    assign count = preset_path ? pdata : cnt_q;

    updn_cascade_out #(.W(W)) u_out (
        .clk      (clk),
        .cnt_en_n (cnt_en_n),
        .down     (down),
        .cur      (count),
        .term     (term),
        .ripple_n (ripple_n)
    );

endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         load_n,
    input logic         cnt_en_n,
    input logic         down,
    input logic [W-1:0] pdata,
    input logic [W-1:0] count,
    input logic         term,
    input logic         ripple_n,
    input logic         running
);

    assert_count_up_R1: assert property (@(posedge clk) disable iff (!load_n)
        (running && !cnt_en_n && !down) |=> (count == $past(count) + 1'b1));

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!load_n)
        (running && !cnt_en_n && down) |=> (count == $past(count) - 1'b1));

    assert_inhibit_R3: assert property (@(posedge clk) disable iff (!load_n)
        (running && cnt_en_n) |=> $stable(count));

    assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!load_n)
        (running && !cnt_en_n && !down && (&count)) |=> (count == '0));

    assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!load_n)
        (running && !cnt_en_n && down && (count == '0)) |=> (&count));

    assert_ripple_low_R7: assert property (@(posedge clk) disable iff (!load_n)
        (term && !cnt_en_n) |-> !ripple_n);

    assert_ripple_quiet_R7: assert property (@(posedge clk) disable iff (!load_n)
        (!term || cnt_en_n) |-> ripple_n);

    assert_ripple_clk_high_R7: assert property (@(negedge clk) disable iff (!load_n)
        ripple_n);

    assert_release_no_step_R8: assert property (@(posedge clk) disable iff (!load_n)
        (!running) |=> (count == $past(pdata)));

endmodule

bind updn_counter updn_counter_chk #(.W(W)) u_chk (
    .clk      (clk),
    .load_n   (load_n),
    .cnt_en_n (cnt_en_n),
    .down     (down),
    .pdata    (pdata),
    .count    (count),
    .term     (term),
    .ripple_n (ripple_n),
    .running  (running)
);

// File: tb/updn_counter_bench.sv
module updn_counter_bench;

    logic       clk      = 1'b0;
    logic       load_n   = 1'b0;
    logic       cnt_en_n = 1'b1;
    logic       down     = 1'b0;
    logic [7:0] pdata    = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       term_lo, term_hi, rip_lo_n, rip_hi_n;
    logic       en_hi_n;
    logic [7:0] q8;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [7:0] model = 8'h00;

    typedef struct {
        logic [7:0] cnt;
        logic       tc;
        logic       rip_n;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    assign en_hi_n = cnt_en_n | ~term_lo;
    assign q8      = {q_hi, q_lo};

    updn_counter #(.W(4)) u_updn_counter (
        .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .down(down),
        .pdata(pdata[3:0]), .count(q_lo), .term(term_lo), .ripple_n(rip_lo_n)
    );

    updn_counter #(.W(4)) u_updn_counter_hi (
        .clk(clk), .load_n(load_n), .cnt_en_n(en_hi_n), .down(down),
        .pdata(pdata[7:4]), .count(q_hi), .term(term_hi), .ripple_n(rip_hi_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic exp_t mk(input string tag);
        exp_t e;
        e.cnt   = model;
        e.tc    = down ? (model[3:0] == 4'h0) : (model[3:0] == 4'hF);
        e.rip_n = !(e.tc && !cnt_en_n);
        e.tag   = tag;
        return e;
    endfunction

    // Driver: apply one cycle of stimulus and predict the count after the edge.
    task automatic step(input logic en, input logic d, input string tag);
        @(negedge clk); #5;
        cnt_en_n = en;
        down     = d;
        if (!en) model = d ? model - 8'd1 : model + 8'd1;
        sb.push_back(mk(tag));
    endtask

    // Control wiggles between edges; only the final levels count (R10).
    task automatic wiggle_hold();
        @(negedge clk); #5;
        cnt_en_n = 1'b0; down = 1'b1;
        #2 cnt_en_n = 1'b0; down = 1'b0;
        #1 cnt_en_n = 1'b1;
        sb.push_back(mk("R10"));
    endtask

    task automatic do_load(input logic [7:0] v);
        @(negedge clk); #4;
        @(posedge clk); #5;
        load_n = 1'b0;
        pdata  = ~v;
        #2 check("R4 clk-high", q8, ~v);
        @(negedge clk); #3;
        pdata = v;
        #1 check("R4 follow", q8, v);
        @(posedge clk); #5;
        check("R4 edge", q8, v);
        @(negedge clk); #5;
        load_n = 1'b1;
        model  = v;
        sb.push_back(mk("R8"));
    endtask

    // Monitor: pop and compare mid-low-phase.
    initial begin
        forever begin
            @(negedge clk); #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, q8, e.cnt);
                check("R6", {7'd0, term_lo}, {7'd0, e.tc});
                check("R7", {7'd0, rip_lo_n}, {7'd0, e.rip_n});
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk); #5;
            if (load_n) check("R7 clk-high", {7'd0, rip_lo_n}, 8'd1);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        check("R4 reset", q8, 8'h00);
        do_load(8'h0D);
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R9 carry");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, "R3");
        wiggle_hold();
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R9 borrow");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R2");
        do_load(8'hFE);
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R5 up");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R5 down");
        step(1'b0, 1'b1, "R2");
        do_load(8'h1F);
        step(1'b1, 1'b0, "R3");
        step(1'b0, 1'b0, "R9 carry");
        step(1'b1, 1'b1, "R3");
        step(1'b1, 1'b0, "R3");
        repeat (3) @(negedge clk);
        #5;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule